// File: doc/BRIEF.md
# PHY Configuration Register Bridge

This block gives a host on a simple valid/ready register port indirect access to a PHY's internal 16-bit configuration register space. The host loads an address or a data word into one shared 32-bit staging register, then writes 1 to a self-clearing strobe register. The strobe latches the staged value, or starts a PHY-side write or read. Software polls a strobe until it reads 0 again. Read results arrive in a separate output register.

On the PHY side the block drives a request/acknowledge port with a 16-bit address, 16-bit write data and 16-bit read data. The PHY can return stale data on the first read after its target address changes. The bridge handles this itself: the first read strobe after an address capture makes two PHY reads and keeps only the second. Later reads of the same address make a single PHY read.

The sequencer `phy_cr_seq` has six states:

- IDLE waits for a strobe.
- CAPTURE holds for `CAP_LAT` cycles after an address or data capture, then returns to IDLE.
- WRITE requests a PHY write and returns to IDLE on acknowledge.
- READ_DUMMY makes the discarded first read and moves to READ_GAP on acknowledge.
- READ_GAP drops the request for one cycle and moves to READ.
- READ makes the kept read, loads data-out on acknowledge and returns to IDLE.

From IDLE a read strobe goes to READ_DUMMY when an address was captured since the last completed read. Otherwise it goes straight to READ.

Top module: `phy_cr_bridge`

## Requirements
- R1: After reset, all four strobe registers and data-out read 0.
- R2: The data-in register at offset 0x0C is read/write over all 32 bits. Data-out at offset 0x10 is read-only and holds the 16-bit PHY result, zero-extended to 32 bits.
- R3: Writing a value with bit 0 set to capture-address (0x14) latches data-in bits 15:0 as the PHY address. Doing the same to capture-data (0x18) latches them as the write data. The written strobe reads 1 for `CAP_LAT` cycles, then reads 0.
- R4: Writing bit 0 = 1 to the write strobe (0x20) performs one PHY write of the captured data to the captured address. The strobe reads 1 until the PHY acknowledges.
- R5: Writing bit 0 = 1 to the read strobe (0x1C) reads the captured address into data-out. The strobe reads 1 until data-out is valid.
- R6: The first read strobe after an address capture makes two PHY reads, with the request low for one cycle between them, and keeps only the second result. Every later read strobe makes exactly one PHY read.
- R7: A strobe written while any operation is busy is ignored. A data-in write during a busy operation leaves that operation's captured values unchanged.
- R8: Data-out keeps its value until the next read completes.
- R9: A strobe write with bit 0 = 0 has no effect.
- R10: The PHY request, address, write data and direction stay stable until acknowledge. The direction is high only for writes.
- R11: A host read is accepted when valid and ready are both high. Its data appears with rvalid one cycle later, for one cycle, and ready is low during that cycle. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Bridge can accept an access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Byte offset of the register |
| host_wdata | input | 32 | Host write data |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |
| phy_req | output | 1 | PHY access request |
| phy_we | output | 1 | PHY access direction, 1 = write |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | PHY acknowledge, one-cycle pulse |
| phy_rdata | input | 16 | PHY read data, valid with acknowledge |

## Verification
The bound checker watches the following on every cycle:
- the PHY request and its address, data and direction stay stable until acknowledge;
- data-out changes only on an acknowledge;
- at most one strobe starts at a time;
- the host read timing of rvalid and ready.

The bench's scenarios cover the behaviours that depend on the content of a sequence:
- the double read after each address capture, against a PHY model that returns stale data on that first read;
- the single read that follows it;
- strobes and data-in writes issued while an operation is busy;
- the busy-then-clear readback of each strobe under acknowledge latencies that vary from one to eight cycles.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

    localparam int HOST_AW = 8;

    localparam logic [HOST_AW-1:0] OFF_DIN   = 8'h0C;
    localparam logic [HOST_AW-1:0] OFF_DOUT  = 8'h10;
    localparam logic [HOST_AW-1:0] OFF_CADDR = 8'h14;
    localparam logic [HOST_AW-1:0] OFF_CDATA = 8'h18;
    localparam logic [HOST_AW-1:0] OFF_RD    = 8'h1C;
    localparam logic [HOST_AW-1:0] OFF_WR    = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_WRITE,
        ST_READ_DUMMY,
        ST_READ_GAP,
        ST_READ
    } seq_state_t;

    typedef struct packed {
        logic caddr;
        logic cdata;
        logic wr;
        logic rd;
    } strobe_t;

endpackage

// File: rtl/phy_cr_hostif.sv
module phy_cr_hostif
    import phy_cr_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_valid,
    output logic               host_ready,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    output logic               host_rvalid,
    output logic [DW-1:0]      host_rdata,
    output logic [DW-1:0]      din_q,
    output strobe_t            start,
    input  strobe_t            busy,
    input  logic               seq_busy,
    input  logic [PW-1:0]      dout
);

    logic          wr_acc;
    logic          rd_acc;
    logic          strobe_ok;
    logic [DW-1:0] rd_mux;

    always_comb begin
        host_ready = !host_rvalid;
        wr_acc     = host_valid && host_ready && host_we;
        rd_acc     = host_valid && host_ready && !host_we;
        strobe_ok  = wr_acc && host_wdata[0] && !seq_busy;
        start.caddr = strobe_ok && (host_addr == OFF_CADDR);
        start.cdata = strobe_ok && (host_addr == OFF_CDATA);
        start.wr    = strobe_ok && (host_addr == OFF_WR);
        start.rd    = strobe_ok && (host_addr == OFF_RD);
    end

    always_comb begin
        unique case (host_addr)
            OFF_DIN:   rd_mux = din_q;
            OFF_DOUT:  rd_mux = DW'(dout);
            OFF_CADDR: rd_mux = DW'(busy.caddr);
            OFF_CDATA: rd_mux = DW'(busy.cdata);
            OFF_RD:    rd_mux = DW'(busy.rd);
            OFF_WR:    rd_mux = DW'(busy.wr);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q       <= '0;
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= rd_acc;
            if (rd_acc) begin
                host_rdata <= rd_mux;
            end
            if (wr_acc && (host_addr == OFF_DIN)) begin
                din_q <= host_wdata;
            end
        end
    end

endmodule

// File: rtl/phy_cr_seq.sv
module phy_cr_seq
    import phy_cr_pkg::*;
#(
    parameter int PW          = 16,
    parameter int CAP_LAT     = 3,
    parameter bit DOUBLE_READ = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       start,
    input  logic [PW-1:0] din_lo,
    output strobe_t       busy,
    output logic          seq_busy,
    output logic          phy_req,
    output logic          phy_we,
    output logic [PW-1:0] phy_addr,
    output logic [PW-1:0] phy_wdata,
    input  logic          phy_ack,
    input  logic [PW-1:0] phy_rdata,
    output logic [PW-1:0] dout
);

    localparam int CW = (CAP_LAT < 2) ? 1 : $clog2(CAP_LAT);
    localparam logic [CW-1:0] CAP_LAST = CW'(CAP_LAT - 1);

    seq_state_t    st, nxt;
    logic [CW-1:0] cap_cnt;
    logic          cap_is_addr;
    logic [PW-1:0] addr_q;
    logic [PW-1:0] data_q;
    logic [PW-1:0] dout_q;
    logic          fresh;
    logic          any_cap;

    assign any_cap = start.caddr || start.cdata;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (any_cap) begin
                    nxt = ST_CAPTURE;
                end else if (start.wr) begin
                    nxt = ST_WRITE;
                end else if (start.rd) begin
                    nxt = fresh ? ST_READ_DUMMY : ST_READ;
                end
            end
            ST_CAPTURE:    if (cap_cnt == CAP_LAST) nxt = ST_IDLE;
            ST_WRITE:      if (phy_ack) nxt = ST_IDLE;
            ST_READ_DUMMY: if (phy_ack) nxt = ST_READ_GAP;
            ST_READ_GAP:   nxt = ST_READ;
            ST_READ:       if (phy_ack) nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        phy_req    = (st == ST_WRITE) || (st == ST_READ_DUMMY) || (st == ST_READ);
        phy_we     = (st == ST_WRITE);
        phy_addr   = addr_q;
        phy_wdata  = data_q;
        dout       = dout_q;
        seq_busy   = (st != ST_IDLE);
        busy.caddr = (st == ST_CAPTURE) && cap_is_addr;
        busy.cdata = (st == ST_CAPTURE) && !cap_is_addr;
        busy.wr    = (st == ST_WRITE);
        busy.rd    = (st == ST_READ_DUMMY) || (st == ST_READ_GAP) || (st == ST_READ);
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_cnt     <= '0;
            cap_is_addr <= 1'b0;
            addr_q      <= '0;
            data_q      <= '0;
            dout_q      <= '0;
        end else begin
            cap_cnt <= (st == ST_CAPTURE) ? cap_cnt + 1'b1 : '0;
            if (st == ST_IDLE) begin
                if (start.caddr) begin
                    addr_q      <= din_lo;
                    cap_is_addr <= 1'b1;
                end else if (start.cdata) begin
                    data_q      <= din_lo;
                    cap_is_addr <= 1'b0;
                end
            end
            if ((st == ST_READ) && phy_ack) begin
                dout_q <= phy_rdata;
            end
        end
    end

    generate
        if (DOUBLE_READ) begin : g_fresh
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    fresh <= 1'b0;
                end else if ((st == ST_IDLE) && start.caddr) begin
                    fresh <= 1'b1;
                end else if ((st == ST_READ) && phy_ack) begin
                    fresh <= 1'b0;
                end
            end
        end else begin : g_nofresh
            assign fresh = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/phy_cr_bridge.sv
module phy_cr_bridge
    import phy_cr_pkg::*;
#(
    parameter int DW          = 32,
    parameter int PW          = 16,
    parameter int CAP_LAT     = 3,
    parameter bit DOUBLE_READ = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_valid,
    output logic               host_ready,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    output logic               host_rvalid,
    output logic [DW-1:0]      host_rdata,
    output logic               phy_req,
    output logic               phy_we,
    output logic [PW-1:0]      phy_addr,
    output logic [PW-1:0]      phy_wdata,
    input  logic               phy_ack,
    input  logic [PW-1:0]      phy_rdata
);

    logic [DW-1:0] din_q;
    strobe_t       start_w;
    strobe_t       busy_w;
    logic          seq_busy;
    logic [PW-1:0] dout_w;

    phy_cr_hostif #(.DW(DW), .PW(PW)) u_hostif (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_valid  (host_valid),
        .host_ready  (host_ready),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rvalid (host_rvalid),
        .host_rdata  (host_rdata),
        .din_q       (din_q),
        .start       (start_w),
        .busy        (busy_w),
        .seq_busy    (seq_busy),
        .dout        (dout_w)
    );

    phy_cr_seq #(.PW(PW), .CAP_LAT(CAP_LAT), .DOUBLE_READ(DOUBLE_READ)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .din_lo    (din_q[PW-1:0]),
        .busy      (busy_w),
        .seq_busy  (seq_busy),
        .phy_req   (phy_req),
        .phy_we    (phy_we),
        .phy_addr  (phy_addr),
        .phy_wdata (phy_wdata),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .dout      (dout_w)
    );

endmodule

// File: rtl/phy_cr_bridge_chk.sv
module phy_cr_bridge_chk #(
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_valid,
    input logic          host_ready,
    input logic          host_we,
    input logic          host_rvalid,
    input logic          phy_req,
    input logic          phy_we,
    input logic [PW-1:0] phy_addr,
    input logic [PW-1:0] phy_wdata,
    input logic          phy_ack,
    input logic [PW-1:0] dout,
    input logic [3:0]    starts
);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> phy_req);

    // R10
    req_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> ($stable(phy_addr) && $stable(phy_wdata) && $stable(phy_we)));

    // R8
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_ack |=> $stable(dout));

    // R7
    one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(starts));

    // R11
    rvalid_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && !host_we) |=> host_rvalid);

    // R11
    rvalid_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> !host_ready);

    // R11
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

endmodule

bind phy_cr_bridge phy_cr_bridge_chk #(.PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_valid  (host_valid),
    .host_ready  (host_ready),
    .host_we     (host_we),
    .host_rvalid (host_rvalid),
    .phy_req     (phy_req),
    .phy_we      (phy_we),
    .phy_addr    (phy_addr),
    .phy_wdata   (phy_wdata),
    .phy_ack     (phy_ack),
    .dout        (dout_w),
    .starts      (start_w)
);

// File: tb/phy_cr_bridge_tb.sv
`timescale 1ns/1ps
module phy_cr_bridge_tb;
    import phy_cr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_rvalid;
    logic [31:0] host_rdata;
    logic        phy_req, phy_we;
    logic [15:0] phy_addr, phy_wdata;
    logic        phy_ack;
    logic [15:0] phy_rdata;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic last_rv, last_rdy;

    always #2 clk = ~clk;

    phy_cr_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    // PHY model: latency 1..8 cycles, stale data on first read after an address change
    logic [15:0] mem [64];
    logic [15:0] prev_addr;
    logic        stale;
    int          cnt, nops, n_wr, n_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_ack   <= 1'b0;
            phy_rdata <= '0;
            prev_addr <= '0;
            stale     <= 1'b0;
            cnt       <= 0;
            nops      <= 0;
            n_wr      <= 0;
            n_rd      <= 0;
            for (int i = 0; i < 64; i++) mem[i] <= 16'h5000 + 16'(i);
        end else begin
            prev_addr <= phy_addr;
            if (phy_addr != prev_addr) stale <= 1'b1;
            if (phy_req && !phy_ack) begin
                if (cnt == (nops % 8)) begin
                    phy_ack <= 1'b1;
                    cnt     <= 0;
                    nops    <= nops + 1;
                    if (phy_we) begin
                        mem[phy_addr[5:0]] <= phy_wdata;
                        n_wr <= n_wr + 1;
                    end else begin
                        phy_rdata <= stale ? 16'hBAD0 : mem[phy_addr[5:0]];
                        stale     <= 1'b0;
                        n_rd      <= n_rd + 1;
                    end
                end else begin
                    cnt <= cnt + 1;
                end
            end else begin
                phy_ack <= 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_we = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_valid = 1'b0;
        d = host_rdata;
        last_rv = host_rvalid;
        last_rdy = host_ready;
    endtask

    task automatic poll(input logic [7:0] a, input string req);
        logic [31:0] v;
        int n = 0;
        do begin
            hread(a, v);
            n++;
        end while (v != 0 && n < 200);
        if (v != 0) chk(req, v, 32'h0);
    endtask

    task automatic cap(input logic [7:0] off, input logic [15:0] v);
        hwrite(OFF_DIN, {16'h0, v});
        hwrite(off, 32'h1);
        poll(off, "R3");
    endtask

    task automatic phy_wr(input logic [15:0] a, input logic [15:0] d);
        cap(OFF_CADDR, a);
        cap(OFF_CDATA, d);
        hwrite(OFF_WR, 32'h1);
        poll(OFF_WR, "R4");
    endtask

    task automatic do_read(output logic [31:0] d);
        hwrite(OFF_RD, 32'h1);
        poll(OFF_RD, "R5");
        hread(OFF_DOUT, d);
    endtask

    localparam logic [31:0] VEC [4] = '{
        {16'h1002, 16'h3F96},
        {16'h1006, 16'h0B80},
        {16'h1010, 16'h0020},
        {16'h102D, 16'h0080}
    };

    initial begin
        logic [31:0] v;
        int r0, w0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        hread(OFF_CADDR, v); chk("R1 caddr", v, 0);
        hread(OFF_CDATA, v); chk("R1 cdata", v, 0);
        hread(OFF_RD, v);    chk("R1 rd", v, 0);
        hread(OFF_WR, v);    chk("R1 wr", v, 0);
        hread(OFF_DOUT, v);  chk("R1 dout", v, 0);
        // R11 read handshake and unmapped offset
        chk("R11 rvalid", {31'b0, last_rv}, 1);
        chk("R11 ready low", {31'b0, last_rdy}, 0);
        hread(8'h04, v); chk("R11 unmapped", v, 0);

        // R2 data-in full width
        hwrite(OFF_DIN, 32'hCAFE1234);
        hread(OFF_DIN, v); chk("R2 din", v, 32'hCAFE1234);

        // R3 capture strobe busy then clear
        hwrite(OFF_DIN, 32'h1002);
        hwrite(OFF_CADDR, 32'h1);
        hread(OFF_CADDR, v); chk("R3 busy", v, 1);
        poll(OFF_CADDR, "R3");
        tests++;

        // Vector table: write, fresh read, repeat read
        for (int i = 0; i < 4; i++) begin
            logic [15:0] a, d;
            a = VEC[i][31:16]; d = VEC[i][15:0];
            phy_wr(a, d);
            chk("R4 mem", {16'h0, mem[a[5:0]]}, {16'h0, d});
            cap(OFF_CADDR, a);
            r0 = n_rd;
            do_read(v);
            chk("R5 R6 fresh data", v, {16'h0, d});
            chk("R6 two reads", n_rd - r0, 2);
            r0 = n_rd;
            do_read(v);
            chk("R6 repeat data", v, {16'h0, d});
            chk("R6 one read", n_rd - r0, 1);
        end

        // R4 write strobe busy until ack
        hwrite(OFF_WR, 32'h1);
        hread(OFF_WR, v); chk("R4 busy", v, 1);
        poll(OFF_WR, "R4");

        // R7 data-in write during capture does not disturb it
        hwrite(OFF_DIN, 32'h1006);
        hwrite(OFF_CADDR, 32'h1);
        hwrite(OFF_DIN, 32'h1002);
        poll(OFF_CADDR, "R7");
        do_read(v);
        chk("R7 din during busy", v, 32'h0B80);

        // R7 strobes during a read are ignored
        w0 = n_wr;
        hwrite(OFF_DIN, 32'h1010);
        hwrite(OFF_CADDR, 32'h1);
        poll(OFF_CADDR, "R7");
        hwrite(OFF_RD, 32'h1);
        hwrite(OFF_WR, 32'h1);
        hwrite(OFF_DIN, 32'h102D);
        hwrite(OFF_CADDR, 32'h1);
        poll(OFF_RD, "R7");
        chk("R7 wr ignored", n_wr - w0, 0);
        r0 = n_rd;
        do_read(v);
        chk("R7 caddr ignored data", v, 32'h0020);
        chk("R7 caddr ignored fresh", n_rd - r0, 1);

        // R8 data-out holds across captures and writes
        phy_wr(16'h1030, 16'h7777);
        hread(OFF_DOUT, v); chk("R8 hold", v, 32'h0020);

        // R9 strobe with bit 0 clear
        r0 = n_rd;
        hwrite(OFF_RD, 32'h2);
        hread(OFF_RD, v); chk("R9 strobe", v, 0);
        repeat (12) @(negedge clk);
        chk("R9 no read", n_rd - r0, 0);
        hread(OFF_DOUT, v); chk("R9 dout", v, 32'h0020);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule